// File: doc/BRIEF.md
# Packed Saturating Integer ALU

This block is a 64-bit SIMD integer datapath for media and signal-processing work. It takes two 64-bit operands and splits them into eight 8-bit, four 16-bit or two 32-bit lanes. On every lane at once it does one of these: an add, a subtract, an equality compare or a signed greater-than compare. It can also do a bitwise AND, AND-NOT or OR across the whole word. Additions and subtractions either wrap modulo the lane width or clamp at the lane's unsigned or signed limits. Each lane clamps on its own, and no carry crosses a lane boundary.

Compares do not set a flag. Each lane of the result is filled with all ones when the condition holds and with all zeros when it does not. The result can then be used as a mask by the bitwise operations, for example to select pixels from one of two images. Short sequences of operations also build branch-free idioms. Two unsigned saturating subtracts ORed together give a per-lane absolute difference. A saturating add, a saturating subtract and a wrapping add together clip each lane to a range.

A valid input is accepted on any cycle. The result and the per-lane carry vector are registered, so they appear one cycle later.

Top module: `simd_satalu`

## Requirements
- R1: `lane_sel` picks the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, and 2 or 3 give two 32-bit lanes. Lane i occupies bits [i*W+W-1 : i*W]. No carry or borrow crosses from one lane to the next.
- R2: With `mode_sel` 0 or 3 (wraparound), an add (`op_sel` 0) or subtract (`op_sel` 1, a minus b) gives the lane result modulo 2^W. For example, 0xFF + 0x01 in a byte lane gives 0x00.
- R3: With `mode_sel` 1 (unsigned saturating), a lane whose true result is above 2^W-1 gives all ones, and a lane whose true result is below zero gives zero.
- R4: With `mode_sel` 2 (signed saturating), a lane clamps at its own signed limits: 0x7F/0x80 for bytes, 0x7FFF/0x8000 for words and 0x7FFFFFFF/0x80000000 for doublewords.
- R5: For an add, `carry` bit i is the unsigned carry-out of lane i. For a subtract, it is the unsigned borrow of lane i (a < b). This holds in every mode. Carry bits above the number of lanes are zero, and the whole of `carry` is zero for every other operation.
- R6: `op_sel` 2 (equal) and `op_sel` 3 (signed a greater than b) fill each lane with all ones when the condition holds and with all zeros otherwise. `mode_sel` has no effect on them.
- R7: `op_sel` 4 gives a AND b, `op_sel` 5 gives (NOT a) AND b, and `op_sel` 6 gives a OR b, all on the full 64 bits. `lane_sel` and `mode_sel` have no effect on them. `op_sel` 7 gives a result of zero.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `result` and `carry` hold their values.
- R9: While `rst` is high, and at the first edge after reset, `out_valid`, `result` and `carry` are zero.
- R10: For any operands q and r, OR-ing the unsigned saturating subtract q-r with the unsigned saturating subtract r-q gives |q-r| in every lane.
- R11: Three byte operations clip each lane of x to [low, high]:
  1. an unsigned saturating add of (0xFF-high);
  2. an unsigned saturating subtract of (0xFF-high+low);
  3. a wrapping add of low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and selects are valid this cycle |
| opa | input | 64 | Operand a |
| opb | input | 64 | Operand b |
| lane_sel | input | 2 | Lane width: 0 byte, 1 word, 2 or 3 doubleword |
| op_sel | input | 3 | 0 add, 1 sub, 2 eq, 3 gt, 4 and, 5 andn, 6 or, 7 zero |
| mode_sel | input | 2 | 0 or 3 wrap, 1 unsigned saturate, 2 signed saturate |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 64 | Registered packed result |
| carry | output | 8 | Registered per-lane carry or borrow |

## Verification
Some checks run on every cycle. These cover the one-cycle valid timing and the holding of outputs between requests. They also cover that a compare leaves only whole-lane masks, and that carry bits beyond the active lane count or outside add/subtract stay zero. Inside each lane, unsigned saturating results never fall below an addend, and never rise above the minuend. A signed add of mixed-sign operands never clamps.

The exact clamp values at each lane width still need the bench's scenarios. So do the separation of lanes and the signedness of the greater-than compare. The bench also has to show the absolute-difference and clipping sequences, and the mask-driven selection between two images.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    LANE_B  = 2'd0,
    LANE_W  = 2'd1,
    LANE_D  = 2'd2,
    LANE_D2 = 2'd3
  } lane_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CEQ  = 3'd2,
    OP_CGT  = 3'd3,
    OP_AND  = 3'd4,
    OP_ANDN = 3'd5,
    OP_OR   = 3'd6,
    OP_NONE = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    M_WRAP  = 2'd0,
    M_USAT  = 2'd1,
    M_SSAT  = 2'd2,
    M_WRAP2 = 2'd3
  } mode_e;
endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith
  import simd_pkg::*;
#(
  parameter int LW = 8
) (
  input  op_e             op,
  input  mode_e           mode,
  input  logic [LW-1:0]   a,
  input  logic [LW-1:0]   b,
  output logic [LW-1:0]   res,
  output logic            cout
);
  localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] ONES = {LW{1'b1}};

  logic [LW:0] sum;
  logic [LW:0] dif;
  logic        ovf_add;
  logic        ovf_sub;

  always_comb begin
    sum     = {1'b0, a} + {1'b0, b};
    dif     = {1'b0, a} - {1'b0, b};
    ovf_add = (a[LW-1] == b[LW-1]) && (sum[LW-1] != a[LW-1]);
    ovf_sub = (a[LW-1] != b[LW-1]) && (dif[LW-1] != a[LW-1]);
    res  = '0;
    cout = 1'b0;
    case (op)
      OP_ADD: begin
        cout = sum[LW];
        case (mode)
          M_USAT:  res = sum[LW] ? ONES : sum[LW-1:0];
          M_SSAT:  res = ovf_add ? (a[LW-1] ? SMIN : SMAX) : sum[LW-1:0];
          default: res = sum[LW-1:0];
        endcase
      end
      OP_SUB: begin
        cout = dif[LW];
        case (mode)
          M_USAT:  res = dif[LW] ? '0 : dif[LW-1:0];
          M_SSAT:  res = ovf_sub ? (a[LW-1] ? SMIN : SMAX) : dif[LW-1:0];
          default: res = dif[LW-1:0];
        endcase
      end
      OP_CEQ:  res = (a == b) ? ONES : '0;
      OP_CGT:  res = ($signed(a) > $signed(b)) ? ONES : '0;
      default: res = '0;
    endcase

    if (op == OP_ADD && mode == M_USAT) begin
      p_usat_add_floor_r3: assert (res >= a && res >= b);
    end
    if (op == OP_SUB && mode == M_USAT) begin
      p_usat_sub_ceil_r3: assert (res <= a);
    end
    if (op == OP_ADD && mode == M_SSAT && (a[LW-1] != b[LW-1])) begin
      p_ssat_mixed_r4: assert (res == LW'(a + b));
    end
  end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LW     = 8
) (
  input  op_e               op,
  input  mode_e             mode,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic [DATA_W/LW-1:0] cout
);
  localparam int NL = DATA_W / LW;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    simd_lane_arith #(.LW(LW)) u_lane (
      .op   (op),
      .mode (mode),
      .a    (a[i*LW +: LW]),
      .b    (b[i*LW +: LW]),
      .res  (res[i*LW +: LW]),
      .cout (cout[i])
    );
  end
endmodule

// File: rtl/simd_satalu.sv
module simd_satalu
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int B_W    = 8,
  parameter int W_W    = 16,
  parameter int D_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [63:0]       opa,
  input  logic [63:0]       opb,
  input  logic [1:0]        lane_sel,
  input  logic [2:0]        op_sel,
  input  logic [1:0]        mode_sel,
  output logic              out_valid,
  output logic [63:0]       result,
  output logic [7:0]        carry
);
  localparam int NB = DATA_W / B_W;
  localparam int NW = DATA_W / W_W;
  localparam int ND = DATA_W / D_W;
  localparam int CW = NB;

  op_e   op;
  mode_e mode;
  lane_e lsel;

  assign op   = op_e'(op_sel);
  assign mode = mode_e'(mode_sel);
  assign lsel = lane_e'(lane_sel);

  logic [DATA_W-1:0] res_b, res_w, res_d;
  logic [NB-1:0]     cy_b;
  logic [NW-1:0]     cy_w;
  logic [ND-1:0]     cy_d;

  simd_lane_bank #(.DATA_W(DATA_W), .LW(B_W)) u_bank_b (
    .op(op), .mode(mode), .a(opa), .b(opb), .res(res_b), .cout(cy_b));
  simd_lane_bank #(.DATA_W(DATA_W), .LW(W_W)) u_bank_w (
    .op(op), .mode(mode), .a(opa), .b(opb), .res(res_w), .cout(cy_w));
  simd_lane_bank #(.DATA_W(DATA_W), .LW(D_W)) u_bank_d (
    .op(op), .mode(mode), .a(opa), .b(opb), .res(res_d), .cout(cy_d));

  logic [DATA_W-1:0] lane_res;
  logic [CW-1:0]     lane_cy;
  logic [DATA_W-1:0] nxt_res;
  logic [CW-1:0]     nxt_cy;

  always_comb begin
    case (lsel)
      LANE_B: begin
        lane_res = res_b;
        lane_cy  = cy_b;
      end
      LANE_W: begin
        lane_res = res_w;
        lane_cy  = {{(CW-NW){1'b0}}, cy_w};
      end
      default: begin
        lane_res = res_d;
        lane_cy  = {{(CW-ND){1'b0}}, cy_d};
      end
    endcase

    nxt_cy = '0;
    case (op)
      OP_ADD, OP_SUB: begin
        nxt_res = lane_res;
        nxt_cy  = lane_cy;
      end
      OP_CEQ, OP_CGT: nxt_res = lane_res;
      OP_AND:         nxt_res = opa & opb;
      OP_ANDN:        nxt_res = ~opa & opb;
      OP_OR:          nxt_res = opa | opb;
      default:        nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        carry  <= nxt_cy;
      end
    end
  end

  function automatic logic lanes_are_masks(logic [DATA_W-1:0] v, lane_e ls);
    int lw;
    logic [DATA_W-1:0] m;
    logic [DATA_W-1:0] f;
    logic ok;
    lw = (ls == LANE_B) ? B_W : (ls == LANE_W) ? W_W : D_W;
    m  = '1;
    m  = m >> (DATA_W - lw);
    ok = 1'b1;
    for (int i = 0; i < NB; i++) begin
      if (i * lw < DATA_W) begin
        f = (v >> (i * lw)) & m;
        if (f != '0 && f != m) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  p_valid_next_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(carry)));
  p_mask_shape_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == OP_CEQ || op_sel == OP_CGT))
      |=> lanes_are_masks(result, $past(lsel)));
  p_carry_pad_d_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sel[1]) |=> (carry[CW-1:ND] == '0));
  p_carry_pad_w_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sel == LANE_W) |=> (carry[CW-1:NW] == '0));
  p_carry_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel != OP_ADD && op_sel != OP_SUB) |=> (carry == '0));
endmodule

// File: tb/tb_simd_satalu.sv
`timescale 1ns/1ps
module tb_simd_satalu;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] opa, opb;
  logic [1:0]  lane_sel;
  logic [2:0]  op_sel;
  logic [1:0]  mode_sel;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  carry;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  simd_satalu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
    .lane_sel(lane_sel), .op_sel(op_sel), .mode_sel(mode_sel),
    .out_valid(out_valid), .result(result), .carry(carry));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] ls,
                                input logic [2:0] op, input logic [1:0] md,
                                output logic [63:0] r, output logic [7:0] c);
    int lw, nl;
    longint umax, half, ua, ub, sa, sb, v;
    logic cb;
    lw   = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    nl   = 64 / lw;
    umax = (longint'(1) << lw) - 1;
    half = longint'(1) << (lw - 1);
    r = '0;
    c = '0;
    for (int i = 0; i < nl; i++) begin
      ua = longint'(a >> (i * lw)) & umax;
      ub = longint'(b >> (i * lw)) & umax;
      sa = (ua >= half) ? ua - 2 * half : ua;
      sb = (ub >= half) ? ub - 2 * half : ub;
      cb = 1'b0;
      v  = 0;
      case (op)
        3'd0: begin
          v  = ua + ub;
          cb = (v > umax);
          if (md == 2'd1 && v > umax) v = umax;
          if (md == 2'd2) begin
            v = sa + sb;
            if (v > half - 1) v = half - 1;
            if (v < -half) v = -half;
          end
        end
        3'd1: begin
          v  = ua - ub;
          cb = (ua < ub);
          if (md == 2'd1 && v < 0) v = 0;
          if (md == 2'd2) begin
            v = sa - sb;
            if (v > half - 1) v = half - 1;
            if (v < -half) v = -half;
          end
        end
        3'd2: v = (ua == ub) ? umax : 0;
        3'd3: v = (sa > sb) ? umax : 0;
        default: v = 0;
      endcase
      r = r | (64'(v & umax) << (i * lw));
      c[i] = cb;
    end
    case (op)
      3'd4: r = a & b;
      3'd5: r = ~a & b;
      3'd6: r = a | b;
      default: ;
    endcase
  endfunction

  task automatic run(input logic [63:0] ia, input logic [63:0] ib, input logic [1:0] ls,
                     input logic [2:0] op, input logic [1:0] md,
                     output logic [63:0] r, output logic [7:0] c);
    @(negedge clk);
    opa = ia; opb = ib; lane_sel = ls; op_sel = op; mode_sel = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = result;
    c = carry;
    chk(out_valid == 1'b1, "R8 out_valid one cycle after in_valid", 64'(out_valid), 64'd1);
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic [1:0] md);
    if (op <= 3'd1) return (md == 2'd1) ? "R3" : (md == 2'd2) ? "R4" : "R2";
    if (op <= 3'd3) return "R6";
    return "R7";
  endfunction

  logic [63:0] r, r2, r3, er, q, s, x, blue, img1, img2, mask, p1, p2;
  logic [7:0]  c, ec;

  initial begin
    rst = 1'b1; in_valid = 1'b0; opa = '0; opb = '0;
    lane_sel = '0; op_sel = '0; mode_sel = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && result == '0 && carry == '0, "R9 reset state",
        result | 64'(carry) | 64'(out_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && result == '0, "R9 idle after reset", result, 64'd0);

    // R2 and R5: byte wrap, carry per lane
    run(64'hFF00_0000_0000_00FF, 64'h0100_0000_0000_0001, 2'd0, 3'd0, 2'd0, r, c);
    chk(r == 64'd0, "R2 byte wrap FF+01", r, 64'd0);
    chk(c == 8'h81, "R5 byte carry-out vector", 64'(c), 64'h81);
    // R1: word lanes carry within lane, not across
    run(64'h0000_00FF_0000_FFFF, 64'h0000_0001_0000_0001, 2'd1, 3'd0, 2'd0, r, c);
    chk(r == 64'h0000_0100_0000_0000, "R1 word lane carry stays inside lane", r, 64'h0000_0100_0000_0000);
    chk(c == 8'h01, "R5 word carry vector", 64'(c), 64'h01);
    // hold check R8
    @(negedge clk);
    opa = ~opa; opb = ~opb; op_sel = 3'd6;
    @(negedge clk);
    chk(result == r && out_valid == 1'b0, "R8 outputs hold while idle", result, r);

    // R3 unsigned saturating byte add
    run(64'h7701_2345_F0AA_F088, 64'h11FF_FF00_7A23_87CE, 2'd0, 3'd0, 2'd1, r, c);
    chk(r == 64'h88FF_FF45_FFCD_FFFF, "R3 unsigned saturating byte add", r, 64'h88FF_FF45_FFCD_FFFF);
    chk(c == 8'h6B, "R5 carry in saturating mode", 64'(c), 64'h6B);
    // R4 signed saturating byte add
    run(64'h7701_2345_F0AA_F088, 64'h11FF_FF00_7A23_87CE, 2'd0, 3'd0, 2'd2, r, c);
    chk(r == 64'h7F00_2245_6ACD_8080, "R4 signed saturating byte add", r, 64'h7F00_2245_6ACD_8080);
    // R4 word
    run(64'h1234_0001_8000_7FFF, 64'h0000_0002_FFFF_0001, 2'd1, 3'd0, 2'd2, r, c);
    chk(r == 64'h1234_0003_8000_7FFF, "R4 signed saturating word add", r, 64'h1234_0003_8000_7FFF);
    // R4 dword subtract
    run(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 2'd2, 3'd1, 2'd2, r, c);
    chk(r == 64'h8000_0000_7FFF_FFFF, "R4 signed saturating dword sub", r, 64'h8000_0000_7FFF_FFFF);
    chk(c == 8'h01, "R5 dword borrow vector", 64'(c), 64'h01);
    // R3 unsigned sub underflow
    run(64'h0010_0005_0000_0100, 64'h0020_0001_0001_0001, 2'd1, 3'd1, 2'd1, r, c);
    chk(r == 64'h0000_0004_0000_00FF, "R3 unsigned saturating word sub", r, 64'h0000_0004_0000_00FF);
    // R6 compares
    run(64'h0000_0000_0000_0507, 64'h0000_0000_0000_0907, 2'd0, 3'd2, 2'd2, r, c);
    chk(r == 64'hFFFF_FFFF_FFFF_00FF, "R6 byte equality mask", r, 64'hFFFF_FFFF_FFFF_00FF);
    run(64'h0000_0000_0000_0001, 64'h0000_0000_0000_00FF, 2'd0, 3'd3, 2'd1, r, c);
    chk(r == 64'h0000_0000_0000_00FF, "R6 signed greater-than mask", r, 64'h0000_0000_0000_00FF);
    chk(c == 8'h00, "R5 carry zero for compare", 64'(c), 64'h0);
    // R7 logic
    run(64'hF0F0_F0F0_F0F0_F0F0, 64'hFFFF_0000_FFFF_0000, 2'd0, 3'd5, 2'd1, r, c);
    chk(r == 64'h0F0F_0000_0F0F_0000, "R7 and-not", r, 64'h0F0F_0000_0F0F_0000);
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 2'd2, 3'd7, 2'd0, r, c);
    chk(r == 64'd0 && c == 8'd0, "R7 reserved op gives zero", r, 64'd0);

    // R7 chroma-style select using a compare mask
    for (int k = 0; k < 6; k++) begin
      blue = 64'h2020_2020_2020_2020;
      img1 = {$urandom, $urandom};
      for (int j = 0; j < 8; j++) if ($urandom % 2) img1[j*8 +: 8] = 8'h20;
      img2 = {$urandom, $urandom};
      run(img1, blue, 2'd0, 3'd2, 2'd0, mask, c);
      run(mask, img2, 2'd0, 3'd4, 2'd0, p1, c);
      run(mask, img1, 2'd0, 3'd5, 2'd0, p2, c);
      run(p1, p2, 2'd0, 3'd6, 2'd0, r, c);
      er = '0;
      for (int j = 0; j < 8; j++) er[j*8 +: 8] = (img1[j*8 +: 8] == 8'h20) ? img2[j*8 +: 8] : img1[j*8 +: 8];
      chk(r == er, "R7 mask select between two images", r, er);
    end

    // R10 absolute difference identity
    for (int k = 0; k < 12; k++) begin
      q = {$urandom, $urandom};
      s = {$urandom, $urandom};
      run(q, s, 2'd0, 3'd1, 2'd1, r, c);
      run(s, q, 2'd0, 3'd1, 2'd1, r2, c);
      run(r, r2, 2'd0, 3'd6, 2'd0, r3, c);
      er = '0;
      for (int j = 0; j < 8; j++)
        er[j*8 +: 8] = (q[j*8 +: 8] > s[j*8 +: 8]) ? q[j*8 +: 8] - s[j*8 +: 8] : s[j*8 +: 8] - q[j*8 +: 8];
      chk(r3 == er, "R10 absolute difference by two saturating subtracts", r3, er);
    end

    // R11 clip to [0x20, 0xC0]
    for (int k = 0; k < 12; k++) begin
      x = (k == 0) ? 64'hF0C1_C020_1F00_FF10 : {$urandom, $urandom};
      run(x, {8{8'h3F}}, 2'd0, 3'd0, 2'd1, r, c);
      run(r, {8{8'h5F}}, 2'd0, 3'd1, 2'd1, r2, c);
      run(r2, {8{8'h20}}, 2'd0, 3'd0, 2'd0, r3, c);
      er = '0;
      for (int j = 0; j < 8; j++)
        er[j*8 +: 8] = (x[j*8 +: 8] < 8'h20) ? 8'h20 : (x[j*8 +: 8] > 8'hC0) ? 8'hC0 : x[j*8 +: 8];
      chk(r3 == er, "R11 saturating clip sequence", r3, er);
    end

    // random mixed against bench model (R1..R7, R5)
    for (int k = 0; k < 300; k++) begin
      logic [1:0] ls, md;
      logic [2:0] op;
      logic [63:0] ia, ib;
      ia = {$urandom, $urandom};
      ib = (k % 4 == 0) ? ~ia : {$urandom, $urandom};
      ls = 2'($urandom % 4);
      op = 3'($urandom % 8);
      md = 2'($urandom % 4);
      model(ia, ib, ls, op, md, er, ec);
      run(ia, ib, ls, op, md, r, c);
      chk(r == er, {tag_of(op, md), " R1 random lane result"}, r, er);
      chk(c == ec, "R5 random carry vector", 64'(c), 64'(ec));
    end

    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid low after last request", 64'(out_valid), 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R8 run did not finish actual=%h expected=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule